// File: doc/BRIEF.md
# Processor Clock-Control Power State Machine

This controller follows the low-power state of a processor core. It moves between running, halted, clock-stopped, sleeping and deep-sleep states. The inputs are active-low requests for stop-clock, sleep, cache flush, bus initialisation, core reset and system-management interrupt. A strap bit picks which of two clock-stopped flavours is used. A halt-instruction pulse, an input-clock-running flag, and completion inputs for the flush, bus-init and system-management phases complete the input set.

Each transition that must produce a bus transaction raises a one-cycle request. A halt transaction is requested only when the core halts from the running state. A stop-grant acknowledge is requested on every entry into a clock-stopped state. Resuming the halted state by any other route emits no halt transaction. While the core sits in the snoop-capable stopped state, it records interrupt requests as single sticky flags. These flags are handed over for service in the cycle the core is running again.

In the snoop-only stopped state the core may only see stop-clock, reset and bus-priority activity. A change on any other monitored input does not move the state. It sets a sticky violation flag instead. All transitions are synchronous to `clk`.

Top module: `clkctl_pwr_fsm`

## Requirements
- R1: The state output uses the codes Normal=0, AutoHalt=1, StopGrant=2, QuickStart=3, Sleep=4, DeepSleep=5, SMM=6, Flushing=7, BusInit=8. After reset it reads 0, and every request, flag and service output is 0.
- R2: In Normal, a halt pulse with no stop-clock or SMI request moves the state to AutoHalt. `halt_cyc` is high for exactly that first AutoHalt cycle.
- R3: In Normal or AutoHalt, asserting stop-clock enters StopGrant when `strap_quick`=0 and QuickStart when it is 1. `sgack_cyc` is high for exactly the first cycle in the new state. Stop-clock has priority over SMI and halt.
- R4: Deasserting stop-clock in StopGrant or QuickStart returns to AutoHalt if the stop began there, and to Normal otherwise. No halt request is emitted.
- R5: An SMI in Normal or AutoHalt enters SMM. `smm_exit` leaves SMM for AutoHalt when `smm_to_halt`=1 and for Normal when it is 0, without a halt request.
- R6: A flush in AutoHalt or StopGrant enters Flushing. `flush_req` stays high there until `flush_done`, and then the state it came from is resumed without a halt request.
- R7: While in StopGrant with stop-clock held, asserted interrupts set sticky flags in `pend`: bit0 SMI, bit1 INIT, bit2 INTR, bit3 NMI. Repeats collapse into one flag. On any entry into Normal, `svc` equals the flags for one cycle and `pend` clears. A return to AutoHalt keeps them.
- R8: A bus-init in StopGrant enters BusInit. On `binit_done` the state goes to StopGrant if stop-clock is still asserted, and otherwise to Normal.
- R9: A reset request in StopGrant or QuickStart keeps the state unchanged. It clears the pending flags and makes the later stop-clock exit go to Normal.
- R10: Asserting sleep in StopGrant enters Sleep. Deasserting it returns to StopGrant.
- R11: When the input clock stops in QuickStart or Sleep, the state moves to DeepSleep. When it restarts, the state returns to the light state it came from.
- R12: In QuickStart, flush, bus-init and interrupts neither change the state nor set pending flags. A change on sleep, flush, bus-init, SMI, INIT, INTR or NMI sets `qs_violation`, which stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous block reset, active low |
| stpclk_n | input | 1 | Stop-clock request, active low |
| slp_n | input | 1 | Sleep request, active low |
| flush_n | input | 1 | Cache flush request, active low |
| binit_n | input | 1 | Bus initialisation request, active low |
| reset_req_n | input | 1 | Core reset request, active low |
| smi_n | input | 1 | System-management interrupt, active low |
| init_n | input | 1 | INIT interrupt, active low |
| intr | input | 1 | Maskable interrupt, active high |
| nmi | input | 1 | Non-maskable interrupt, active high |
| strap_quick | input | 1 | 1 selects QuickStart, 0 selects StopGrant |
| halt_pulse | input | 1 | Halt instruction executed |
| clk_running | input | 1 | Core input clock is running |
| smm_exit | input | 1 | System-management handler finished |
| smm_to_halt | input | 1 | Resume AutoHalt (1) or Normal (0) after SMM |
| flush_done | input | 1 | Cache flush complete |
| binit_done | input | 1 | Bus initialisation complete |
| state | output | 4 | Current power state code |
| halt_cyc | output | 1 | One-cycle halt bus transaction request |
| sgack_cyc | output | 1 | One-cycle stop-grant acknowledge request |
| flush_req | output | 1 | Cache flush in progress |
| pend | output | 4 | Sticky pending interrupt flags |
| svc | output | 4 | Flags released for service, one cycle |
| qs_violation | output | 1 | Sticky illegal-input-change flag |

## Verification
A wrong internal state shows directly on `state` in the cycle after the input edge that caused it. A stale return-origin bit stays hidden until the later stop-clock release, flush completion or deep-sleep wake. It then shows as a wrong resume code or as a spurious halt request. A fault in the interrupt flags shows on `pend` one cycle after the assertion, or only at the next entry into Normal through `svc`. For that reason the bench compares every output against a behavioural model on every clock, over sequences that pass through each return path.

// File: rtl/clkctl_pwr_fsm.sv
module clkctl_pwr_fsm #(
  parameter int STW = 4,
  parameter int NIRQ = 4,
  localparam int NMON = NIRQ + 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            stpclk_n,
  input  logic            slp_n,
  input  logic            flush_n,
  input  logic            binit_n,
  input  logic            reset_req_n,
  input  logic            smi_n,
  input  logic            init_n,
  input  logic            intr,
  input  logic            nmi,
  input  logic            strap_quick,
  input  logic            halt_pulse,
  input  logic            clk_running,
  input  logic            smm_exit,
  input  logic            smm_to_halt,
  input  logic            flush_done,
  input  logic            binit_done,
  output logic [STW-1:0]  state,
  output logic            halt_cyc,
  output logic            sgack_cyc,
  output logic            flush_req,
  output logic [NIRQ-1:0] pend,
  output logic [NIRQ-1:0] svc,
  output logic            qs_violation
);

  localparam logic [STW-1:0] S_NORMAL = STW'(0);
  localparam logic [STW-1:0] S_HALT   = STW'(1);
  localparam logic [STW-1:0] S_STOPG  = STW'(2);
  localparam logic [STW-1:0] S_QUICK  = STW'(3);
  localparam logic [STW-1:0] S_SLEEP  = STW'(4);
  localparam logic [STW-1:0] S_DEEP   = STW'(5);
  localparam logic [STW-1:0] S_SMM    = STW'(6);
  localparam logic [STW-1:0] S_FLUSH  = STW'(7);
  localparam logic [STW-1:0] S_BINIT  = STW'(8);
  localparam logic [NMON-1:0] MON_IDLE = {{(NMON-2){1'b1}}, 2'b00};

  logic [STW-1:0]  st, nx, low_st;
  logic            from_halt, from_halt_nx;
  logic            flush_to_sg, flush_to_sg_nx;
  logic            deep_to_sleep, deep_to_sleep_nx;
  logic            hc_nx, ack_nx;
  logic [NIRQ-1:0] irq;
  logic [NMON-1:0] mon, mon_q;
  logic            stp, hold_sg, rst_in_sg;

  assign stp       = !stpclk_n;
  assign low_st    = strap_quick ? S_QUICK : S_STOPG;
  assign irq       = {nmi, intr, !init_n, !smi_n};
  assign mon       = {slp_n, flush_n, binit_n, smi_n, init_n, intr, nmi};
  assign hold_sg   = (st == S_STOPG) && stp;
  assign rst_in_sg = hold_sg && !reset_req_n;
  assign state     = st;
  assign flush_req = (st == S_FLUSH);

  always_comb begin
    nx = st;
    from_halt_nx = from_halt;
    flush_to_sg_nx = flush_to_sg;
    deep_to_sleep_nx = deep_to_sleep;
    hc_nx = 1'b0;
    ack_nx = 1'b0;
    case (st)
      S_NORMAL: begin
        if (stp) begin
          nx = low_st; from_halt_nx = 1'b0; ack_nx = 1'b1;
        end else if (!smi_n) nx = S_SMM;
        else if (halt_pulse) begin
          nx = S_HALT; hc_nx = 1'b1;
        end
      end
      S_HALT: begin
        if (stp) begin
          nx = low_st; from_halt_nx = 1'b1; ack_nx = 1'b1;
        end else if (!smi_n) nx = S_SMM;
        else if (!flush_n) begin
          nx = S_FLUSH; flush_to_sg_nx = 1'b0;
        end
      end
      S_SMM:   if (smm_exit) nx = smm_to_halt ? S_HALT : S_NORMAL;
      S_FLUSH: if (flush_done) nx = flush_to_sg ? S_STOPG : S_HALT;
      S_STOPG: begin
        if (!stp) nx = from_halt ? S_HALT : S_NORMAL;
        else if (!reset_req_n) from_halt_nx = 1'b0;
        else if (!binit_n) nx = S_BINIT;
        else if (!flush_n) begin
          nx = S_FLUSH; flush_to_sg_nx = 1'b1;
        end else if (!slp_n) nx = S_SLEEP;
      end
      S_BINIT: begin
        if (binit_done) begin
          nx = stp ? S_STOPG : S_NORMAL; from_halt_nx = 1'b0;
        end
      end
      S_QUICK: begin
        if (!stp) nx = from_halt ? S_HALT : S_NORMAL;
        else if (!reset_req_n) from_halt_nx = 1'b0;
        else if (!clk_running) begin
          nx = S_DEEP; deep_to_sleep_nx = 1'b0;
        end
      end
      S_SLEEP: begin
        if (slp_n) nx = S_STOPG;
        else if (!clk_running) begin
          nx = S_DEEP; deep_to_sleep_nx = 1'b1;
        end
      end
      S_DEEP:  if (clk_running) nx = deep_to_sleep ? S_SLEEP : S_QUICK;
      default: nx = S_NORMAL;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_NORMAL;
      from_halt <= 1'b0;
      flush_to_sg <= 1'b0;
      deep_to_sleep <= 1'b0;
      halt_cyc <= 1'b0;
      sgack_cyc <= 1'b0;
      pend <= '0;
      svc <= '0;
      qs_violation <= 1'b0;
      mon_q <= MON_IDLE;
    end else begin
      st <= nx;
      from_halt <= from_halt_nx;
      flush_to_sg <= flush_to_sg_nx;
      deep_to_sleep <= deep_to_sleep_nx;
      halt_cyc <= hc_nx;
      sgack_cyc <= ack_nx;
      mon_q <= mon;
      if (st == S_QUICK && mon != mon_q) qs_violation <= 1'b1;
      if (nx == S_NORMAL && st != S_NORMAL) begin
        svc <= pend;
        pend <= '0;
      end else begin
        svc <= '0;
        if (rst_in_sg) pend <= '0;
        else if (hold_sg) pend <= pend | irq;
      end
    end
  end

  AST_HALT_ONLY_FROM_NORMAL: assert property (@(posedge clk) disable iff (!rst_n)
    halt_cyc |-> (st == S_HALT && $past(st) == S_NORMAL)); // R2
  AST_ACK_ON_STOP_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    sgack_cyc |-> ((st == S_STOPG || st == S_QUICK) && ($past(st) == S_NORMAL || $past(st) == S_HALT))); // R3
  AST_PEND_SET_IN_SG: assert property (@(posedge clk) disable iff (!rst_n)
    (|(pend & ~$past(pend))) |-> $past(st) == S_STOPG); // R7
  AST_SVC_ON_NORMAL_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (|svc) |-> (st == S_NORMAL && $past(st) != S_NORMAL)); // R7
  AST_DEEP_FROM_LIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_DEEP && $past(st) != S_DEEP) |-> ($past(st) == S_QUICK || $past(st) == S_SLEEP)); // R11
  AST_VIOL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    qs_violation |=> qs_violation); // R12

endmodule

// File: tb/clkctl_pwr_fsm_tb.sv
module clkctl_pwr_fsm_tb;
  logic clk = 0, rst_n = 0;
  logic stpclk_n = 1, slp_n = 1, flush_n = 1, binit_n = 1, reset_req_n = 1;
  logic smi_n = 1, init_n = 1, intr = 0, nmi = 0, strap_quick = 0, halt_pulse = 0;
  logic clk_running = 1, smm_exit = 0, smm_to_halt = 0, flush_done = 0, binit_done = 0;
  logic [3:0] state, pend, svc;
  logic halt_cyc, sgack_cyc, flush_req, qs_violation;
  int errors = 0, checks = 0, cycles = 0;

  clkctl_pwr_fsm u_dut (.clk(clk), .rst_n(rst_n), .stpclk_n(stpclk_n), .slp_n(slp_n),
    .flush_n(flush_n), .binit_n(binit_n), .reset_req_n(reset_req_n), .smi_n(smi_n),
    .init_n(init_n), .intr(intr), .nmi(nmi), .strap_quick(strap_quick),
    .halt_pulse(halt_pulse), .clk_running(clk_running), .smm_exit(smm_exit),
    .smm_to_halt(smm_to_halt), .flush_done(flush_done), .binit_done(binit_done),
    .state(state), .halt_cyc(halt_cyc), .sgack_cyc(sgack_cyc), .flush_req(flush_req),
    .pend(pend), .svc(svc), .qs_violation(qs_violation));

  always #10 clk = ~clk;

  // behavioural reference
  int ms, mh, ma, mp, msv, mv, m_orig_halt, m_fl_sg, m_deep_sl;
  int prev_mon;
  always @(posedge clk) begin
    int ns, irqv, mon_now;
    if (!rst_n) begin
      ms = 0; mh = 0; ma = 0; mp = 0; msv = 0; mv = 0;
      m_orig_halt = 0; m_fl_sg = 0; m_deep_sl = 0; prev_mon = 'b1111100;
    end else begin
      ns = ms; mh = 0; ma = 0;
      irqv = (smi_n ? 0 : 1) + (init_n ? 0 : 2) + (intr ? 4 : 0) + (nmi ? 8 : 0);
      mon_now = {slp_n, flush_n, binit_n, smi_n, init_n, intr, nmi};
      if (ms == 3 && mon_now != prev_mon) mv = 1;
      prev_mon = mon_now;
      if (ms == 0 || ms == 1) begin
        if (!stpclk_n) begin ns = strap_quick ? 3 : 2; m_orig_halt = (ms == 1); ma = 1; end
        else if (!smi_n) ns = 6;
        else if (ms == 0 && halt_pulse) begin ns = 1; mh = 1; end
        else if (ms == 1 && !flush_n) begin ns = 7; m_fl_sg = 0; end
      end else if (ms == 6) begin
        if (smm_exit) ns = smm_to_halt ? 1 : 0;
      end else if (ms == 7) begin
        if (flush_done) ns = m_fl_sg ? 2 : 1;
      end else if (ms == 2 || ms == 3) begin
        if (stpclk_n) ns = m_orig_halt ? 1 : 0;
        else if (!reset_req_n) m_orig_halt = 0;
        else if (ms == 2 && !binit_n) ns = 8;
        else if (ms == 2 && !flush_n) begin ns = 7; m_fl_sg = 1; end
        else if (ms == 2 && !slp_n) ns = 4;
        else if (ms == 3 && !clk_running) begin ns = 5; m_deep_sl = 0; end
      end else if (ms == 8) begin
        if (binit_done) begin ns = stpclk_n ? 0 : 2; m_orig_halt = 0; end
      end else if (ms == 4) begin
        if (slp_n) ns = 2;
        else if (!clk_running) begin ns = 5; m_deep_sl = 1; end
      end else if (ms == 5) begin
        if (clk_running) ns = m_deep_sl ? 4 : 3;
      end
      if (ns == 0 && ms != 0) begin msv = mp; mp = 0; end
      else begin
        msv = 0;
        if (ms == 2 && !stpclk_n) mp = reset_req_n ? (mp | irqv) : 0;
      end
      ms = ns;
    end
  end

  always @(negedge clk) if (rst_n) begin
    checks++;
    if (state != ms || halt_cyc != mh || sgack_cyc != ma || flush_req != (ms == 7) ||
        pend != mp || svc != msv || qs_violation != mv) begin
      errors++;
      $display("FAIL model compare t=%0t: act st=%0d h=%0d a=%0d p=%0d s=%0d v=%0d exp st=%0d h=%0d a=%0d p=%0d s=%0d v=%0d",
        $time, state, halt_cyc, sgack_cyc, pend, svc, qs_violation, ms, mh, ma, mp, msv, mv);
    end
  end

  task automatic step(int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  initial begin
    step(3); rst_n = 1; step();
    chk("R1 state", state, 0); chk("R1 flags", {halt_cyc, sgack_cyc, flush_req, qs_violation}, 0);
    chk("R1 pend", pend, 0);
    halt_pulse = 1; step(); halt_pulse = 0;
    chk("R2 state", state, 1); chk("R2 halt_cyc", halt_cyc, 1);
    step(); chk("R2 halt one cycle", halt_cyc, 0);
    stpclk_n = 0; step();
    chk("R3 stopgrant", state, 2); chk("R3 sgack", sgack_cyc, 1);
    smi_n = 0; nmi = 1; step(); nmi = 0; step(); smi_n = 1; step();
    chk("R7 pend collapse", pend, 9);
    stpclk_n = 1; step();
    chk("R4 back to halt", state, 1); chk("R4 no halt", halt_cyc, 0); chk("R7 kept", pend, 9);
    flush_n = 0; step(); flush_n = 1;
    chk("R6 flushing", state, 7); chk("R6 flush_req", flush_req, 1);
    step(2); chk("R6 hold", flush_req, 1);
    flush_done = 1; step(); flush_done = 0;
    chk("R6 resume halt", state, 1); chk("R6 no halt", halt_cyc, 0);
    smi_n = 0; step(); smi_n = 1; chk("R5 smm", state, 6);
    smm_to_halt = 0; smm_exit = 1; step(); smm_exit = 0;
    chk("R5 exit normal", state, 0); chk("R7 svc", svc, 9); chk("R7 cleared", pend, 0);
    step(); chk("R7 svc one cycle", svc, 0);
    stpclk_n = 0; step(); chk("R3 from normal", state, 2);
    binit_n = 0; step(); binit_n = 1; chk("R8 businit", state, 8);
    binit_done = 1; step(); binit_done = 0; chk("R8 back to sg", state, 2);
    flush_n = 0; step(); flush_n = 1; flush_done = 1; step(); flush_done = 0;
    chk("R6 resume sg", state, 2);
    intr = 1; step(); intr = 0; chk("R7 intr", pend, 4);
    reset_req_n = 0; step(); reset_req_n = 1;
    chk("R9 stays sg", state, 2); chk("R9 pend cleared", pend, 0);
    slp_n = 0; step(); chk("R10 sleep", state, 4);
    clk_running = 0; step(); chk("R11 deep", state, 5);
    clk_running = 1; step(); chk("R11 wake sleep", state, 4);
    slp_n = 1; step(); chk("R10 back sg", state, 2);
    binit_n = 0; step(); binit_n = 1; stpclk_n = 1; binit_done = 1; step(); binit_done = 0;
    chk("R8 to normal", state, 0);
    strap_quick = 1; halt_pulse = 1; step(); halt_pulse = 0;
    stpclk_n = 0; step(); chk("R3 quickstart", state, 3); chk("R3 ack qs", sgack_cyc, 1);
    flush_n = 0; intr = 1; step(); flush_n = 1; intr = 0; step();
    chk("R12 ignored", state, 3); chk("R12 no flush", flush_req, 0);
    chk("R12 no pend", pend, 0); chk("R12 violation", qs_violation, 1);
    clk_running = 0; step(); chk("R11 deep qs", state, 5);
    clk_running = 1; step(); chk("R11 wake qs", state, 3);
    stpclk_n = 1; step(); chk("R4 qs to halt", state, 1); chk("R4 no halt qs", halt_cyc, 0);
    smi_n = 0; step(); smi_n = 1; smm_to_halt = 1; smm_exit = 1; step(); smm_exit = 0;
    chk("R5 exit halt", state, 1); chk("R5 no halt", halt_cyc, 0);
    chk("R12 still set", qs_violation, 1);
    step(2);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    forever begin
      @(posedge clk); cycles++;
      if (cycles > 5000) begin
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end
endmodule